// File: doc/BRIEF.md
# Multi-Mode Flit Forwarding Stage

This block is one output-facing forwarding stage of an on-chip packet router. Flits arrive on a valid/ready input and are held in a local first-in first-out buffer. A controller then decides, cycle by cycle, whether the flit at the head of that buffer may go out on the downstream link. The downstream router's free space is tracked with a credit counter. The counter is spent by one for every flit sent and is given back by one for every pulse on the credit-return input.

A two-bit mode input picks one of three policies for letting a packet leave. In store-and-forward, the complete packet must sit in the local buffer and the downstream side must have room for all of it. In cut-through, only the downstream room for the whole packet is required. In wormhole, a single free downstream slot is enough for each flit. The packet length is taken from the header flit. Once a packet has started, the choice of policy stays fixed for that packet, and a mode change applies from the next packet on.

Top module: `flit_fwd_stage`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, the buffer is empty and the credit count equals DN_DEPTH, so DN_DEPTH flits can be sent before any credit is returned.
- R2: Flit type sits in bits [FLIT_W-1:FLIT_W-2]: 01 header, 00 body, 10 tail, 11 single-flit packet. A header carries the packet length L (all flits, header included, L at least 2) in bits [LEN_W-1:0]. A single-flit packet has L = 1.
- R3: Mode 00 (store-and-forward): a packet's first flit leaves only when at least L flits are buffered and the credit count is at least L. When both hold and the stage is between packets, it leaves in that cycle.
- R4: Mode 01 (cut-through): a packet's first flit leaves when it is buffered and the credit count is at least L, whether or not the rest has arrived.
- R5: Modes 10 and 11 (wormhole): any flit leaves whenever one is buffered and the credit count is at least 1.
- R6: After a store-and-forward or cut-through packet has started, its remaining flits leave in every cycle in which one is buffered, with no new check against L, until the tail is sent.
- R7: The mode input is sampled only when a packet's first flit leaves. A change while a packet is partly sent does not affect that packet.
- R8: The credit count falls by one per flit sent and rises by one per credit-return pulse. It never exceeds DN_DEPTH, and a return pulse at DN_DEPTH is ignored.
- R9: No flit is issued while the credit count is zero, in any mode.
- R10: in_ready is 0 exactly while BUF_DEPTH flits are buffered. Flits leave in arrival order with no loss or duplication, including when one is accepted in the same cycle as one departs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Forwarding policy: 00 store-and-forward, 01 cut-through, 1x wormhole |
| in_valid | input | 1 | Upstream flit present |
| in_ready | output | 1 | Stage can accept a flit this cycle |
| in_flit | input | FLIT_W | Upstream flit |
| out_valid | output | 1 | Flit issued downstream this cycle |
| out_flit | output | FLIT_W | Downstream flit |
| credit_ret | input | 1 | One downstream slot freed |

## Verification
The embedded properties hold on every cycle. The credit count never exceeds the downstream depth and the buffer never overfills. A started store-and-forward or cut-through packet keeps enough reserved credit for its remaining flits and is never stalled while a flit is buffered. The first flit of each packet is a header or a single flit, and every later flit is a body or a tail. Whether a start is held back for the right reason in each mode can only be shown by the bench's scenarios, which compare out_valid on each cycle with a model of buffered flits and credits. Those scenarios cover slow arrivals in store-and-forward, credit shortage in cut-through, credit exhaustion and a full buffer in wormhole, a mode change in mid-packet, ignored surplus credit returns, and the maximum packet length.

// File: rtl/flit_fwd_stage.sv
module flit_fwd_stage #(
  parameter int FLIT_W    = 16,
  parameter int LEN_W     = 4,
  parameter int BUF_DEPTH = 16,
  parameter int DN_DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              out_valid,
  output logic [FLIT_W-1:0] out_flit,
  input  logic              credit_ret
);

  localparam int PTR_W = $clog2(BUF_DEPTH);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);
  localparam int CR_W  = $clog2(DN_DEPTH + 1);
  localparam int MX1   = (CNT_W > CR_W) ? CNT_W : CR_W;
  localparam int NW    = ((MX1 > LEN_W) ? MX1 : LEN_W) + 1;

  localparam logic [1:0] MODE_SAF = 2'b00;
  localparam logic [1:0] MODE_VCT = 2'b01;
  localparam logic [1:0] TY_BODY  = 2'b00;
  localparam logic [1:0] TY_HEAD  = 2'b01;
  localparam logic [1:0] TY_TAIL  = 2'b10;
  localparam logic [1:0] TY_ONE   = 2'b11;

  logic [FLIT_W-1:0] mem [BUF_DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic [CR_W-1:0]   credits;
  logic              active;
  logic              wh_run;
  logic [NW-1:0]     rem;

  wire [FLIT_W-1:0] head     = mem[rd_ptr];
  wire [1:0]        head_ty  = head[FLIT_W-1 -: 2];
  wire [NW-1:0]     head_len = (head_ty == TY_ONE) ? NW'(1) : NW'(head[LEN_W-1:0]);
  wire [NW-1:0]     cnt_n    = NW'(count);
  wire [NW-1:0]     cred_n   = NW'(credits);
  wire              have     = (count != '0);
  wire              cred_any = (credits != '0);

  logic start_ok;
  always_comb begin
    case (mode)
      MODE_SAF: start_ok = (cnt_n >= head_len) && (cred_n >= head_len);
      MODE_VCT: start_ok = (cred_n >= head_len);
      default:  start_ok = 1'b1;
    endcase
  end

  wire send   = have && cred_any && (active || start_ok);
  wire push   = in_valid && in_ready;
  wire ret_ok = credit_ret && (credits != CR_W'(DN_DEPTH));

  assign in_ready  = (count != CNT_W'(BUF_DEPTH));
  assign out_valid = send;
  assign out_flit  = head;

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= in_flit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(BUF_DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (send) rd_ptr <= (rd_ptr == PTR_W'(BUF_DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, send})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credits <= CR_W'(DN_DEPTH);
    end else begin
      case ({send, ret_ok})
        2'b10:   credits <= credits - 1'b1;
        2'b01:   credits <= credits + 1'b1;
        default: credits <= credits;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      wh_run <= 1'b0;
      rem    <= '0;
    end else if (send) begin
      if (!active) begin
        if (head_len > NW'(1)) begin
          active <= 1'b1;
          rem    <= head_len - NW'(1);
          wh_run <= mode[1];
        end
      end else begin
        rem <= rem - NW'(1);
        if (rem == NW'(1)) active <= 1'b0;
      end
    end
  end

  // R8
  credit_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    credits <= CR_W'(DN_DEPTH));

  // R10
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(BUF_DEPTH));

  // R10
  push_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !send) |=> have);

  // R6
  reserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !wh_run) |-> (cred_n >= rem));

  // R6
  stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !wh_run && have) |-> out_valid);

  // R2
  flit_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (active ? (head_ty == TY_BODY || head_ty == TY_TAIL)
                          : (head_ty == TY_HEAD || head_ty == TY_ONE)));

endmodule

// File: tb/sim_flit_fwd_stage.sv
module sim_flit_fwd_stage;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 16;
  localparam int LW = 4;
  localparam int BD = 16;
  localparam int DD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [FW-1:0] in_flit = '0;
  logic out_valid;
  logic [FW-1:0] out_flit;
  logic credit_ret = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flit_fwd_stage #(.FLIT_W(FW), .LEN_W(LW), .BUF_DEPTH(BD), .DN_DEPTH(DD)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_flit(in_flit), .out_valid(out_valid), .out_flit(out_flit), .credit_ret(credit_ret));

  logic [FW-1:0] q[$];
  int nchk = 0, nfail = 0, cycles = 0;
  int cm = DD, sink_held = 0, sent_total = 0, acc_total = 0;
  bit active_b = 0, lmode_wh = 0, ret_en = 1, extra_ret = 0;
  int rem_b = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_flit(input logic [FW-1:0] f);
    in_flit = f;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
    q.push_back(f);
    acc_total++;
  endtask

  task automatic send_pkt(input int len, input int gap, input logic [7:0] tag);
    for (int i = 0; i < len; i++) begin
      logic [1:0] ty;
      logic [3:0] lo;
      ty = (len == 1) ? 2'b11 : (i == 0) ? 2'b01 : (i == len - 1) ? 2'b10 : 2'b00;
      lo = (i == 0) ? 4'(len) : 4'(i);
      put_flit({ty, tag, 2'b00, lo});
      if (gap > 0 && i < len - 1) repeat (gap) @(negedge clk);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      if (q.size() == 0 && sink_held == 0 && !active_b) break;
      @(negedge clk);
    end
  endtask

  always @(negedge clk) begin
    #1;
    credit_ret = extra_ret || (ret_en && sink_held > 0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      chk(0, "watchdog", cycles, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      int pend, lf;
      bit ev, sent_now, ret_now;
      string tag;
      logic [FW-1:0] f;
      pend = q.size();
      lf = 0;
      if (pend > 0) lf = (q[0][FW-1 -: 2] == 2'b11) ? 1 : int'(q[0][LW-1:0]);
      if (active_b) begin
        ev = (pend > 0) && (cm > 0);
        tag = lmode_wh ? "R5" : "R6";
      end else if (pend == 0) begin
        ev = 0;
        tag = "R10";
      end else begin
        case (mode)
          2'b00: begin ev = (pend >= lf) && (cm >= lf); tag = "R3"; end
          2'b01: begin ev = (cm >= lf); tag = "R4"; end
          default: begin ev = (cm >= 1); tag = "R5"; end
        endcase
      end
      chk(out_valid == ev, tag, out_valid, ev);
      if (cm == 0) chk(!out_valid, "R9", out_valid, 0);
      chk(in_ready == (pend < BD), "R10", in_ready, pend < BD);
      sent_now = 0;
      if (out_valid) begin
        sent_now = 1;
        if (q.size() == 0) chk(0, "R10", 1, 0);
        else begin
          f = q.pop_front();
          chk(out_flit == f, "R10", out_flit, f);
        end
        sent_total++;
        sink_held++;
        if (!active_b) begin
          if (lf > 1) begin
            active_b = 1;
            rem_b = lf - 1;
            lmode_wh = mode[1];
          end
        end else begin
          rem_b--;
          if (rem_b == 0) active_b = 0;
        end
      end
      ret_now = credit_ret && (cm < DD);
      if (credit_ret && sink_held > 0 && !extra_ret) sink_held--;
      cm = cm - int'(sent_now) + int'(ret_now);
    end
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(out_valid == 0, "R1", out_valid, 0);
    chk(in_ready == 1, "R1", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R8: exactly DD flits leave on reset credits
    ret_en = 0; mode = 2'b10;
    s0 = sent_total;
    for (int i = 0; i < DD + 2; i++) send_pkt(1, 0, 8'(i));
    repeat (30) @(negedge clk);
    chk(sent_total - s0 == DD, "R1", sent_total - s0, DD);
    ret_en = 1;
    drain();

    // R3: slow arrivals in store-and-forward
    mode = 2'b00;
    send_pkt(5, 3, 8'h30);
    drain();

    // R4: cut-through with plenty of credit
    mode = 2'b01;
    send_pkt(6, 2, 8'h40);
    drain();

    // R4: cut-through start held for credit shortage
    ret_en = 0; mode = 2'b10;
    for (int i = 0; i < DD - 3; i++) send_pkt(1, 0, 8'h50);
    repeat (20) @(negedge clk);
    mode = 2'b01;
    s0 = sent_total;
    send_pkt(4, 0, 8'h51);
    repeat (10) @(negedge clk);
    chk(sent_total == s0, "R4", sent_total - s0, 0);
    ret_en = 1;
    drain();

    // R3: maximum length and single flit in store-and-forward
    mode = 2'b00;
    send_pkt(15, 1, 8'h60);
    send_pkt(1, 0, 8'h61);
    drain();

    // R10 R9: credits exhausted, buffer fills
    ret_en = 0; mode = 2'b10;
    for (int i = 0; i < DD; i++) send_pkt(1, 0, 8'h70);
    repeat (5) @(negedge clk);
    for (int i = 0; i < BD; i++) send_pkt(1, 0, 8'h71);
    fork
      send_pkt(1, 0, 8'h72);
      begin
        repeat (6) @(negedge clk);
        #1;
        chk(in_ready == 0, "R10", in_ready, 0);
        #2;
        ret_en = 1;
      end
    join
    drain();

    // R7: mode change in the middle of a wormhole packet
    mode = 2'b10;
    fork
      send_pkt(6, 2, 8'h80);
      begin repeat (4) @(negedge clk); mode = 2'b00; end
    join
    send_pkt(3, 2, 8'h81);
    drain();
    // R7: cut-through packet, switch to wormhole midway
    mode = 2'b01;
    fork
      send_pkt(5, 3, 8'h82);
      begin repeat (5) @(negedge clk); mode = 2'b10; end
    join
    drain();

    // R8: surplus returns at full credit are ignored
    extra_ret = 1;
    repeat (4) @(negedge clk);
    extra_ret = 0;
    ret_en = 0; mode = 2'b11;
    s0 = sent_total;
    for (int i = 0; i < DD + 2; i++) send_pkt(1, 0, 8'h90);
    repeat (30) @(negedge clk);
    chk(sent_total - s0 == DD, "R8", sent_total - s0, DD);
    ret_en = 1;
    drain();

    // R5 R2: back-to-back mixed packets with mode 11
    mode = 2'b11;
    send_pkt(2, 0, 8'hA0);
    send_pkt(3, 0, 8'hA1);
    send_pkt(1, 0, 8'hA2);
    send_pkt(4, 0, 8'hA3);
    drain();

    // R10: nothing lost or duplicated
    chk(q.size() == 0, "R10", q.size(), 0);
    chk(sent_total == acc_total, "R10", sent_total, acc_total);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule